// File: doc/BRIEF.md
# Tri-statable audio serial transmitter

This block sends outgoing PCM samples, most significant bit first, onto one serial data line that can be shared with other devices in a time-division frame. A clock generator outside the block supplies one-cycle strobes for the rising and falling bit-clock edges, along with the word-clock level. The block picks one of the two strobes as its launch edge. Each launch opens a new bit slot. Slot 0 is the launch at which the word clock is first seen high after being low. A sample's data window starts a programmed number of slots later, and it lasts for the chosen word length.

Other devices can own the remaining slots. The line can therefore be released outside the window. A keeper option models a weak latch that holds the last driven level while the line is released.

Samples are written into a holding register and are taken over at each frame start. If no new sample arrives in time, the block sends the old one again and flags an underrun. If the window runs past the end of the frame, the bits that do not fit are dropped and an overflow is flagged.

Top module: `aud_tx_serializer`

## Requirements
- R1: During and after reset, before any launch edge, `dout`, `dout_oe`, `keep_hold`, `underrun` and `overflow` are all 0.
- R2: The word length code sets the word length: 2'b00 is 16 bits, 2'b01 is 20, 2'b10 is 24 and 2'b11 is 32. The low N bits of the sample are sent MSB first, one bit per slot, and `dout_oe` is 1 for each of these bits.
- R3: Slot 0 is the launch at which `wclk` is 1 and was 0 at the previous launch. The first data bit goes out in the slot numbered `cfg_offset`, which can be 0 to 255.
- R4: With `cfg_tristate` = 0, every slot outside the data window drives `dout` = 0 with `dout_oe` = 1. This includes slots before the first frame start.
- R5: With `cfg_tristate` = 1 and `cfg_keeper` = 0, every slot outside the window gives `dout_oe` = 0, `dout` = 0 and `keep_hold` = 0.
- R6: With `cfg_tristate` = 1 and `cfg_keeper` = 1, every slot outside the window gives `dout_oe` = 0 and `keep_hold` = 1. In those slots `dout` holds the last value that was driven.
- R7: With `cfg_edge_inv` = 0, `bclk_rise` launches the slots. With `cfg_edge_inv` = 1, `bclk_fall` launches them. The strobe that is not selected changes no output and no frame state.
- R8: A frame start takes the newest sample written since the previous frame start. If several writes arrive in between, the last one wins.
- R9: At a frame start with no new write, the previous sample is sent again, and `underrun` is 1 for the cycle after that launch.
- R10: If `cfg_offset` plus the word length is greater than `cfg_frame_len`, then `overflow` is 1 for the cycle after the frame-start launch. Slots at or beyond `cfg_frame_len` are treated as outside the window.
- R11: Each output changes only in the clock cycle after a launch strobe and is stable in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | 2 | Word length code |
| cfg_offset | input | 8 | Slot of the first data bit after frame start |
| cfg_frame_len | input | 9 | Bit slots per frame, 1 to 256 |
| cfg_tristate | input | 1 | Release the line outside the data window |
| cfg_keeper | input | 1 | Hold the last level while released |
| cfg_edge_inv | input | 1 | Launch on the falling-edge strobe instead of the rising one |
| bclk_rise | input | 1 | One-cycle strobe at each bit-clock rising edge |
| bclk_fall | input | 1 | One-cycle strobe at each bit-clock falling edge |
| wclk | input | 1 | Word-clock level |
| smp_wr | input | 1 | Write strobe for the holding register |
| smp_data | input | 32 | Sample to send, right-aligned |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Output enable for the data line |
| keep_hold | output | 1 | Keeper is holding the released line |
| underrun | output | 1 | Pulse: previous sample resent |
| overflow | output | 1 | Pulse: window exceeds frame |

## Verification
The bench builds the block with its default parameters: a 32-bit sample path, 8-bit offsets and 9-bit frame lengths. This makes all four word lengths and frames of up to 256 slots reachable. The bench runs a short pulse word clock and a 50% duty word clock. It covers both launch edges, each line-release mode, and windows that start at slot 0, start late, or run past the frame end. The 10-bit slot counter saturates at 1023, well beyond any window the configuration can describe, so saturation stays out of reach.

// File: rtl/aud_tx_pkg.sv
// Shared helpers for the audio serial transmitter.
// Assumes the word length code has four values and that no word exceeds 32 bits.
package aud_tx_pkg;

    // Converts the two-bit word length code to a bit count.
    function automatic logic [5:0] word_bits(input logic [1:0] code);
        case (code)
            2'b00:   word_bits = 6'd16;
            2'b01:   word_bits = 6'd20;
            2'b10:   word_bits = 6'd24;
            default: word_bits = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/aud_tx_frame_timer.sv
// Picks the launch strobe, detects frame start and numbers the bit slots.
// Assumes each strobe is high for one clk cycle per bit-clock edge and that
// wclk is stable around the launch strobes.
// slot_o and synced_o refer to the slot being launched and are valid
// while launch_o is high.
module aud_tx_frame_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_inv,
    input  logic             rise_stb,
    input  logic             fall_stb,
    input  logic             wclk,
    output logic             launch_o,
    output logic             frame_start_o,
    output logic             synced_o,
    output logic [CNT_W-1:0] slot_o
);
    localparam logic [CNT_W-1:0] SLOT_MAX = '1;

    logic             prev_w;
    logic             sync_q;
    logic [CNT_W-1:0] cnt;

    // Selects the launch edge and derives this slot's number.
    always_comb begin
        launch_o      = edge_inv ? fall_stb : rise_stb;
        frame_start_o = launch_o && wclk && !prev_w;
        synced_o      = sync_q || frame_start_o;
        if (frame_start_o)
            slot_o = '0;
        else if (cnt == SLOT_MAX)
            slot_o = SLOT_MAX;
        else
            slot_o = cnt + CNT_W'(1);
    end

    // Records word-clock level, slot number and sync state at each launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_w <= 1'b0;
            sync_q <= 1'b0;
            cnt    <= '0;
        end else if (launch_o) begin
            prev_w <= wclk;
            sync_q <= synced_o;
            cnt    <= slot_o;
        end
    end

    // R3
    slot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> (cnt == '0) && sync_q);

    // R7
    frozen_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !launch_o |=> $stable(cnt) && $stable(prev_w) && $stable(sync_q));
endmodule

// File: rtl/aud_tx_sample_store.sv
// Holding register plus the sample currently being sent.
// At a frame start the held sample moves to the current sample if it is new.
// Otherwise the current sample is kept and an underrun pulse is raised.
// Assumes writes do not coincide with a frame-start launch.
module aud_tx_sample_store #(
    parameter int SMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_wr,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             load,
    output logic [SMP_W-1:0] sample_o,
    output logic             underrun_o
);
    logic [SMP_W-1:0] held;
    logic [SMP_W-1:0] cur;
    logic             fresh;

    // Provides the sample for the slot being launched.
    always_comb begin
        sample_o = (load && fresh) ? held : cur;
    end

    // Accepts writes and hands samples over at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held       <= '0;
            cur        <= '0;
            fresh      <= 1'b0;
            underrun_o <= 1'b0;
        end else begin
            underrun_o <= load && !fresh;
            if (load && fresh)
                cur <= held;
            if (smp_wr) begin
                held  <= smp_data;
                fresh <= 1'b1;
            end else if (load) begin
                fresh <= 1'b0;
            end
        end
    end

    // R9
    resend_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !fresh) |=> $stable(cur) && underrun_o);

    // R8
    consume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !smp_wr) |=> !fresh);
endmodule

// File: rtl/aud_tx_line_driver.sv
// Decides for each launched slot whether it carries a data bit.
// Picks the bit, MSB first, and drives, zeroes or releases the line.
// Assumes SMP_W is at least 32, so every word length fits in the sample.
// Outputs are registered and change only in the cycle after a launch.
module aud_tx_line_driver
    import aud_tx_pkg::*;
#(
    parameter int SMP_W = 32,
    parameter int OFS_W = 8,
    parameter int FRM_W = 9,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             frame_start,
    input  logic             synced,
    input  logic [CNT_W-1:0] slot,
    input  logic [SMP_W-1:0] sample,
    input  logic [1:0]       len_code,
    input  logic [OFS_W-1:0] offset,
    input  logic [FRM_W-1:0] frame_len,
    input  logic             tristate,
    input  logic             keeper,
    output logic             dout_o,
    output logic             oe_o,
    output logic             hold_o,
    output logic             overflow_o
);
    localparam int IDX_W = $clog2(SMP_W);

    logic [CNT_W-1:0] len_w, off_w, flen_w, win_end, rel, bpos;
    logic [IDX_W-1:0] bidx;
    logic             in_win, data_bit, last_q, too_long;

    // Computes the data window and the bit for this slot.
    always_comb begin
        len_w    = CNT_W'(word_bits(len_code));
        off_w    = CNT_W'(offset);
        flen_w   = CNT_W'(frame_len);
        win_end  = off_w + len_w;
        rel      = slot - off_w;
        bpos     = len_w - CNT_W'(1) - rel;
        bidx     = IDX_W'(bpos);
        data_bit = sample[bidx];
        in_win   = synced && (slot >= off_w) && (slot < win_end) && (slot < flen_w);
        too_long = win_end > flen_w;
    end

    // Registers the line state and the overflow pulse at each launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o     <= 1'b0;
            oe_o       <= 1'b0;
            hold_o     <= 1'b0;
            last_q     <= 1'b0;
            overflow_o <= 1'b0;
        end else begin
            overflow_o <= launch && frame_start && too_long;
            if (launch) begin
                if (in_win) begin
                    dout_o <= data_bit;
                    oe_o   <= 1'b1;
                    hold_o <= 1'b0;
                    last_q <= data_bit;
                end else if (!tristate) begin
                    dout_o <= 1'b0;
                    oe_o   <= 1'b1;
                    hold_o <= 1'b0;
                    last_q <= 1'b0;
                end else begin
                    dout_o <= keeper ? last_q : 1'b0;
                    oe_o   <= 1'b0;
                    hold_o <= keeper;
                end
            end
        end
    end

    // R11
    quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable(dout_o) && $stable(oe_o) && $stable(hold_o));

    // R6
    keeper_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> !oe_o);

    // R6
    keeper_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && $past(hold_o)) |-> $stable(dout_o));

    // R4
    driven_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !tristate) |=> oe_o && !hold_o);

    // R10
    overflow_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> $past(launch));
endmodule

// File: rtl/aud_tx_serializer.sv
// Top of the audio serial transmitter.
// Ties together slot timing, sample hand-over and line drive.
// Assumes the bit-clock strobes and wclk come from a clock generator in the clk domain.
module aud_tx_serializer #(
    parameter int SMP_W = 32,
    parameter int OFS_W = 8,
    parameter int FRM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_len,
    input  logic [OFS_W-1:0] cfg_offset,
    input  logic [FRM_W-1:0] cfg_frame_len,
    input  logic             cfg_tristate,
    input  logic             cfg_keeper,
    input  logic             cfg_edge_inv,
    input  logic             bclk_rise,
    input  logic             bclk_fall,
    input  logic             wclk,
    input  logic             smp_wr,
    input  logic [SMP_W-1:0] smp_data,
    output logic             dout,
    output logic             dout_oe,
    output logic             keep_hold,
    output logic             underrun,
    output logic             overflow
);
    localparam int CNT_W = FRM_W + 1;

    logic             launch, frame_start, synced;
    logic [CNT_W-1:0] slot;
    logic [SMP_W-1:0] sample;

    aud_tx_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .edge_inv      (cfg_edge_inv),
        .rise_stb      (bclk_rise),
        .fall_stb      (bclk_fall),
        .wclk          (wclk),
        .launch_o      (launch),
        .frame_start_o (frame_start),
        .synced_o      (synced),
        .slot_o        (slot)
    );

    aud_tx_sample_store #(.SMP_W(SMP_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_wr     (smp_wr),
        .smp_data   (smp_data),
        .load       (frame_start),
        .sample_o   (sample),
        .underrun_o (underrun)
    );

    aud_tx_line_driver #(
        .SMP_W (SMP_W),
        .OFS_W (OFS_W),
        .FRM_W (FRM_W),
        .CNT_W (CNT_W)
    ) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .frame_start (frame_start),
        .synced      (synced),
        .slot        (slot),
        .sample      (sample),
        .len_code    (cfg_len),
        .offset      (cfg_offset),
        .frame_len   (cfg_frame_len),
        .tristate    (cfg_tristate),
        .keeper      (cfg_keeper),
        .dout_o      (dout),
        .oe_o        (dout_oe),
        .hold_o      (keep_hold),
        .overflow_o  (overflow)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !dout_oe && !keep_hold && !underrun && !overflow);
endmodule

// File: tb/test_aud_tx_serializer.sv
`timescale 1ns/1ps
module test_aud_tx_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_len = 2'b00;
    logic [7:0]  cfg_offset = 8'd0;
    logic [8:0]  cfg_frame_len = 9'd32;
    logic        cfg_tristate = 1'b0, cfg_keeper = 1'b0, cfg_edge_inv = 1'b0;
    logic        bclk_rise = 1'b0, bclk_fall = 1'b0, wclk = 1'b0;
    logic        smp_wr = 1'b0;
    logic [31:0] smp_data = '0;
    logic        dout, dout_oe, keep_hold, underrun, overflow;

    always #2.5 clk = ~clk;

    aud_tx_serializer i_aud_tx_serializer (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_offset(cfg_offset),
        .cfg_frame_len(cfg_frame_len), .cfg_tristate(cfg_tristate),
        .cfg_keeper(cfg_keeper), .cfg_edge_inv(cfg_edge_inv),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .wclk(wclk),
        .smp_wr(smp_wr), .smp_data(smp_data), .dout(dout), .dout_oe(dout_oe),
        .keep_hold(keep_hold), .underrun(underrun), .overflow(overflow)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Expected {dout, oe, hold, underrun, overflow} per launched slot.
    logic [4:0] exp_q[$];
    string      tag_q[$];

    // Reference model state.
    bit          m_prev_w = 0, m_sync = 0, m_fresh = 0, m_last = 0;
    int          m_cnt = 0;
    logic [31:0] m_held = '0, m_cur = '0;

    function automatic int len_of(input logic [1:0] c);
        case (c)
            2'b00: return 16;
            2'b01: return 20;
            2'b10: return 24;
            default: return 32;
        endcase
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (dout,oe,hold,unr,ovf)", tag, act, exp);
        end
    endtask

    // Monitor: compare outputs one cycle after every selected launch strobe.
    logic tick_q = 1'b0;
    always @(posedge clk) tick_q <= cfg_edge_inv ? bclk_fall : bclk_rise;
    always @(negedge clk) begin
        if (tick_q && rst_n) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R11: output update with no expected item");
            end else begin
                check(tag_q.pop_front(), {dout, dout_oe, keep_hold, underrun, overflow},
                      exp_q.pop_front());
            end
        end
    end

    task automatic write_smp(input logic [31:0] v);
        @(negedge clk);
        smp_wr = 1'b1; smp_data = v;
        @(negedge clk);
        smp_wr = 1'b0;
        m_held = v; m_fresh = 1;
    endtask

    // Driver: launch one slot and push the model's expected result.
    task automatic slot(input bit w, input string tag);
        bit st, inw, d, oe, h, unr, ovf;
        int k, len, off, fl;
        @(negedge clk);
        wclk = w;
        if (cfg_edge_inv) bclk_fall = 1'b1; else bclk_rise = 1'b1;
        st = w && !m_prev_w;
        m_prev_w = w;
        k = st ? 0 : ((m_cnt >= 1023) ? 1023 : m_cnt + 1);
        m_cnt = k;
        if (st) m_sync = 1;
        unr = 0;
        if (st) begin
            if (m_fresh) begin m_cur = m_held; m_fresh = 0; end
            else unr = 1;
        end
        len = len_of(cfg_len); off = int'(cfg_offset); fl = int'(cfg_frame_len);
        ovf = st && (off + len > fl);
        inw = m_sync && k >= off && k < off + len && k < fl;
        if (inw) begin
            d = m_cur[len - 1 - (k - off)]; oe = 1; h = 0; m_last = d;
        end else if (!cfg_tristate) begin
            d = 0; oe = 1; h = 0; m_last = 0;
        end else begin
            d = cfg_keeper ? m_last : 0; oe = 0; h = cfg_keeper;
        end
        exp_q.push_back({d, oe, h, unr, ovf});
        tag_q.push_back(tag);
        @(negedge clk);
        bclk_rise = 1'b0; bclk_fall = 1'b0;
    endtask

    task automatic frame(input int n, input int hi, input string tag);
        for (int i = 0; i < n; i++) slot(i < hi, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] snap;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", {dout, dout_oe, keep_hold, underrun, overflow}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {dout, dout_oe, keep_hold, underrun, overflow}, 5'b0);

        // R4: slots before the first frame start drive 0 when not tri-stated
        slot(0, "R4"); slot(0, "R4");

        // R2: 16-bit words, offset 0, pulse word clock
        write_smp(32'h0000_A5C3);
        frame(32, 1, "R2");
        cfg_len = 2'b01; cfg_frame_len = 9'd24;
        write_smp(32'h000B_3E69);
        frame(24, 1, "R2");

        // R3: 24-bit words at offset 1 (one-slot delay)
        cfg_len = 2'b10; cfg_offset = 8'd1; cfg_frame_len = 9'd32;
        write_smp(32'h00C3_5A0F);
        frame(32, 16, "R3");

        // R4: offset window with driven zeros around it
        cfg_len = 2'b00; cfg_offset = 8'd5; cfg_frame_len = 9'd24;
        write_smp(32'h0000_F00D);
        frame(24, 1, "R4");

        // R5: released line, no keeper, 20-bit word
        cfg_tristate = 1'b1; cfg_len = 2'b01; cfg_offset = 8'd7; cfg_frame_len = 9'd40;
        write_smp(32'h000F_FFFF);
        frame(40, 1, "R5");

        // R6: keeper holds the last bit, 32-bit word, 50% word clock
        cfg_keeper = 1'b1; cfg_len = 2'b11; cfg_offset = 8'd0; cfg_frame_len = 9'd64;
        write_smp(32'h8000_0001);
        frame(64, 32, "R6");

        // R8: two writes before a frame, the later one is sent
        write_smp(32'h1111_1111);
        write_smp(32'h9E37_79B9);
        frame(48, 1, "R8");

        // R9: no write, previous sample resent with underrun pulse
        frame(40, 1, "R9");

        // R10: window runs past frame end
        cfg_keeper = 1'b0; cfg_len = 2'b10; cfg_offset = 8'd20; cfg_frame_len = 9'd32;
        write_smp(32'h00FF_FF00);
        frame(36, 1, "R10");
        cfg_tristate = 1'b0;
        write_smp(32'h00AB_CDEF);
        frame(34, 1, "R10");

        // R7: with falling-edge launch, rising strobes change nothing
        cfg_edge_inv = 1'b1;
        @(negedge clk);
        snap = {dout, dout_oe, keep_hold, underrun, overflow};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); wclk = 1'b1; bclk_rise = 1'b1;
            @(negedge clk); bclk_rise = 1'b0; wclk = 1'b0;
            @(negedge clk);
            check("R7", {dout, dout_oe, keep_hold, underrun, overflow}, snap);
        end
        cfg_len = 2'b00; cfg_offset = 8'd2; cfg_frame_len = 9'd20;
        write_smp(32'h0000_6C4B);
        frame(20, 1, "R7");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11: %0d expected items never observed (expected 0)", exp_q.size());
        end
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule